// File: doc/BRIEF.md
# Flash Host Boot Reader

This block is the host-side sequencer that pulls boot data out of a managed-flash device. When a boot request arrives and a non-zero size multiplier is configured, it drives the command line low in push-pull mode. It keeps the line low while boot data flows. It can optionally wait for a three-bit acknowledge on data line 0. It then waits for the first data start bit, and counts the good blocks reported by a separate receive datapath. That datapath does the deserialization and the CRC checking.

The block releases the command line by driving it high. Release happens for one of four reasons: the configured amount of data has arrived, a deadline has expired, a CRC failure was reported, or the requester aborted. Whatever the reason, the line never stays low for fewer than the minimum number of clocks. Once released, the line is held high for a quiet gap. At the end of the gap the block strobes a one-cycle signal meaning that the next command, CMD1, may be sent. All deadlines are clock counts set by parameters. The number of 512-byte blocks per 128 KB size unit is also a parameter.

Top module: `flash_boot_reader`

## Requirements
- R1: After reset the state code is 0 (idle), `cmd_oe_o` is 0, `cmd_o` is 1, and all error flags and `cmd1_ready_o` are 0. The state codes are: 0 idle, 1 waiting for acknowledge, 2 waiting for first data, 3 transferring, 4 holding low to the minimum, 5 quiet gap.
- R2: A start request accepted in idle makes the block drive the command line low (`cmd_oe_o`=1, `cmd_o`=0) from the next cycle. The line then stays low for at least MIN_LOW_CLKS cycles, whatever triggers the release. An early release request waits in state 4.
- R3: With acknowledge enabled, the block enters state 1. It moves to state 2 on the cycle after it samples DAT0 as 0, 1, 0 on three consecutive cycles. If no such pattern is seen within the first ACK_TO_CLKS low cycles, `err_ack_o` is set and the line goes high after exactly ACK_TO_CLKS low cycles.
- R4: In state 2, a DAT0 sample of 0 moves the block to state 3. If no start bit is seen within the first DATA_TO_CLKS low cycles, counted from when the line went low, `err_data_o` is set and the line goes high after exactly DATA_TO_CLKS low cycles.
- R5: In state 3, once multiplier × BLOCKS_PER_UNIT blocks have completed with a good CRC, the line goes high in the cycle after the last block-done pulse. It does not go high earlier.
- R6: From release until the end of the gap, the command line is actively driven high (`cmd_oe_o`=1, `cmd_o`=1) in state 5.
- R7: `cmd1_ready_o` pulses for one cycle in the GAP_CLKS-th high cycle. In the next cycle the state is idle and `cmd_oe_o` is 0.
- R8: An abort with `abort_now_i`=1 releases the line in the next cycle, subject to R2. Block-done pulses after that are ignored.
- R9: An abort with `abort_now_i`=0 during state 3 keeps the line low until the next block-done pulse, then releases it. In state 1 or 2 it releases at once.
- R10: A block-done pulse with a bad CRC sets `err_crc_o` and releases the line in the next cycle, subject to R2.
- R11: A start request is ignored outside idle, and also when the multiplier is 0. Error flags stay set until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_start_i | input | 1 | Request to begin a boot read |
| abort_i | input | 1 | Early termination request |
| abort_now_i | input | 1 | With abort: 1 = immediate, 0 = at next block boundary |
| dat0_i | input | 1 | Sampled DAT0 line |
| blk_done_i | input | 1 | Receive datapath finished a block |
| blk_crc_ok_i | input | 1 | CRC result qualifying `blk_done_i` |
| cfg_ack_en_i | input | 1 | Expect the acknowledge pattern |
| cfg_size_mult_i | input | MULT_W | Boot size in 128 KB units |
| cmd_oe_o | output | 1 | Command line output enable (push-pull) |
| cmd_o | output | 1 | Command line level |
| state_o | output | 3 | State code (see R1) |
| err_ack_o | output | 1 | Acknowledge deadline missed |
| err_data_o | output | 1 | First-data deadline missed |
| err_crc_o | output | 1 | A block failed CRC |
| cmd1_ready_o | output | 1 | One-cycle strobe: CMD1 may be issued |

## Verification
The bench measures the exact low duration of each termination path. An off-by-one in a deadline compare, or a deadline counted from the wrong moment, shifts the release cycle, and the bench catches that. An abort placed well before the minimum low time shows whether the line is released early. A design that skipped the hold state would drive the line high after a handful of cycles. Boundary aborts are checked for holding the line through the rest of the block; a design that treats them as immediate releases too soon. The gap strobe is checked for its exact position, and start requests sent while busy or with a zero multiplier are checked for having no effect. A misplaced strobe would let CMD1 collide with the quiet period.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ACK       = 3'd1,
    ST_WAIT_DATA = 3'd2,
    ST_XFER      = 3'd3,
    ST_HOLD      = 3'd4,
    ST_GAP       = 3'd5
  } fbr_state_e;

  // Number of 512-byte blocks making up the whole boot area.
  function automatic logic [31:0] boot_blocks(input logic [31:0] mult,
                                              input logic [31:0] per_unit);
    return mult * per_unit;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fbr_low_timer.sv
module fbr_low_timer #(
  parameter int unsigned ACK_TO_CLKS  = 2600000,
  parameter int unsigned DATA_TO_CLKS = 52000000,
  parameter int unsigned MIN_LOW_CLKS = 74,
  localparam int unsigned CMAX = fbr_pkg::max3(ACK_TO_CLKS, DATA_TO_CLKS, MIN_LOW_CLKS),
  localparam int unsigned TW   = $clog2(CMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [TW-1:0] low_cnt_o,
  output logic          ack_late_o,
  output logic          data_late_o,
  output logic          min_met_o
);

  logic [TW-1:0] low_q;

  // Cycles the command line has been low; zero in the first low cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   low_q <= '0;
    else if (clear_i)                             low_q <= '0;
    else if (run_i && (low_q != TW'(CMAX)))       low_q <= low_q + 1'b1;
  end

  assign low_cnt_o   = low_q;
  assign ack_late_o  = low_q >= TW'(ACK_TO_CLKS - 1);
  assign data_late_o = low_q >= TW'(DATA_TO_CLKS - 1);
  assign min_met_o   = low_q >= TW'(MIN_LOW_CLKS - 1);

endmodule

// File: rtl/fbr_dat0_watch.sv
module fbr_dat0_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic dat0_i,
  output logic ack_hit_o,
  output logic start_bit_o
);

  logic [1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= 2'b11;
    else if (clear_i) hist_q <= 2'b11;
    else              hist_q <= {hist_q[0], dat0_i};
  end

  // Oldest sample first: 0, then 1, then the current 0.
  assign ack_hit_o   = ({hist_q, dat0_i} == 3'b010);
  assign start_bit_o = !dat0_i;

endmodule

// File: rtl/fbr_blk_count.sv
module fbr_blk_count #(
  parameter int unsigned MULT_W    = 8,
  parameter int unsigned PER_UNIT  = 256,
  localparam int unsigned CNT_W    = MULT_W + $clog2(PER_UNIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              blk_ok_i,
  output logic              last_o
);

  logic [MULT_W-1:0] mult_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  total;

  assign total = CNT_W'(fbr_pkg::boot_blocks(32'(mult_q), 32'(PER_UNIT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      mult_q <= mult_i;
      cnt_q  <= '0;
    end else if (blk_ok_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last_o = blk_ok_i && (cnt_q == total - 1'b1);

  // R5: no good block is ever counted beyond the configured total
  assert_blk_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ok_i |-> (cnt_q < total))
    else $error("good block counted beyond configured total");

endmodule

// File: rtl/fbr_gap_timer.sv
module fbr_gap_timer #(
  parameter int unsigned GAP_CLKS = 56,
  localparam int unsigned GW      = $clog2(GAP_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (!run_i) gap_q <= '0;
    else if (!done_o) gap_q <= gap_q + 1'b1;
  end

  assign done_o = run_i && (gap_q == GW'(GAP_CLKS - 1));

  // R7: the quiet-gap count never passes its length
  assert_gap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(gap_q) < GAP_CLKS)
    else $error("gap counter overran");

endmodule

// File: rtl/flash_boot_reader.sv
module flash_boot_reader
  import fbr_pkg::*;
#(
  parameter int unsigned MULT_W          = 8,
  parameter int unsigned BLOCKS_PER_UNIT = 256,
  parameter int unsigned ACK_TO_CLKS     = 2600000,
  parameter int unsigned DATA_TO_CLKS    = 52000000,
  parameter int unsigned MIN_LOW_CLKS    = 74,
  parameter int unsigned GAP_CLKS        = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_start_i,
  input  logic              abort_i,
  input  logic              abort_now_i,
  input  logic              dat0_i,
  input  logic              blk_done_i,
  input  logic              blk_crc_ok_i,
  input  logic              cfg_ack_en_i,
  input  logic [MULT_W-1:0] cfg_size_mult_i,
  output logic              cmd_oe_o,
  output logic              cmd_o,
  output logic [2:0]        state_o,
  output logic              err_ack_o,
  output logic              err_data_o,
  output logic              err_crc_o,
  output logic              cmd1_ready_o
);

  localparam int unsigned TW = $clog2(max3(ACK_TO_CLKS, DATA_TO_CLKS, MIN_LOW_CLKS) + 1);

  fbr_state_e    state_q, state_d;
  logic          in_low, start_ok;
  logic          blk_ok, blk_bad, blk_last;
  logic          ack_hit, start_bit;
  logic          ack_late, data_late, min_met;
  logic [TW-1:0] low_cnt;
  logic          gap_done;
  logic          rel_req, set_ack, set_data, set_crc, pend_set;
  logic          abort_pend_q;
  logic          err_ack_q, err_data_q, err_crc_q;

  assign in_low   = state_q inside {ST_ACK, ST_WAIT_DATA, ST_XFER, ST_HOLD};
  assign start_ok = (state_q == ST_IDLE) && boot_start_i && (|cfg_size_mult_i);
  assign blk_ok   = (state_q == ST_XFER) && blk_done_i && blk_crc_ok_i;
  assign blk_bad  = (state_q == ST_XFER) && blk_done_i && !blk_crc_ok_i;

  fbr_low_timer #(
    .ACK_TO_CLKS (ACK_TO_CLKS),
    .DATA_TO_CLKS(DATA_TO_CLKS),
    .MIN_LOW_CLKS(MIN_LOW_CLKS)
  ) u_low (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_ok),
    .run_i      (in_low),
    .low_cnt_o  (low_cnt),
    .ack_late_o (ack_late),
    .data_late_o(data_late),
    .min_met_o  (min_met)
  );

  fbr_dat0_watch u_dat0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_ok),
    .dat0_i     (dat0_i),
    .ack_hit_o  (ack_hit),
    .start_bit_o(start_bit)
  );

  fbr_blk_count #(
    .MULT_W  (MULT_W),
    .PER_UNIT(BLOCKS_PER_UNIT)
  ) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_ok),
    .mult_i  (cfg_size_mult_i),
    .blk_ok_i(blk_ok),
    .last_o  (blk_last)
  );

  fbr_gap_timer #(
    .GAP_CLKS(GAP_CLKS)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == ST_GAP),
    .done_o(gap_done)
  );

  always_comb begin
    state_d  = state_q;
    rel_req  = 1'b0;
    set_ack  = 1'b0;
    set_data = 1'b0;
    set_crc  = 1'b0;
    pend_set = 1'b0;
    case (state_q)
      ST_IDLE: if (start_ok) state_d = cfg_ack_en_i ? ST_ACK : ST_WAIT_DATA;
      ST_ACK: begin
        if (abort_i)       rel_req = 1'b1;
        else if (ack_hit)  state_d = ST_WAIT_DATA;
        else if (ack_late) begin rel_req = 1'b1; set_ack = 1'b1; end
      end
      ST_WAIT_DATA: begin
        if (abort_i)        rel_req = 1'b1;
        else if (start_bit) state_d = ST_XFER;
        else if (data_late) begin rel_req = 1'b1; set_data = 1'b1; end
      end
      ST_XFER: begin
        if (blk_bad)                                            begin rel_req = 1'b1; set_crc = 1'b1; end
        else if (blk_ok && (blk_last || abort_pend_q || abort_i)) rel_req  = 1'b1;
        else if (abort_i && abort_now_i)                          rel_req  = 1'b1;
        else if (abort_i)                                         pend_set = 1'b1;
      end
      ST_HOLD: if (min_met)  state_d = ST_GAP;
      ST_GAP:  if (gap_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (rel_req) state_d = min_met ? ST_GAP : ST_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      abort_pend_q <= 1'b0;
      err_ack_q    <= 1'b0;
      err_data_q   <= 1'b0;
      err_crc_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      abort_pend_q <= (state_q == ST_XFER) && (abort_pend_q || pend_set);
      if (start_ok) begin
        err_ack_q  <= 1'b0;
        err_data_q <= 1'b0;
        err_crc_q  <= 1'b0;
      end else begin
        err_ack_q  <= err_ack_q  | set_ack;
        err_data_q <= err_data_q | set_data;
        err_crc_q  <= err_crc_q  | set_crc;
      end
    end
  end

  assign cmd_oe_o     = (state_q != ST_IDLE);
  assign cmd_o        = !in_low;
  assign state_o      = state_q;
  assign err_ack_o    = err_ack_q;
  assign err_data_o   = err_data_q;
  assign err_crc_o    = err_crc_q;
  assign cmd1_ready_o = gap_done;

  // R2: the line only enters the gap once the minimum low time is met
  assert_min_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_GAP) |-> $past(min_met))
    else $error("command line released before minimum low time");

  // R3: acknowledge wait never outlives its deadline
  assert_ack_deadline_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK) |-> (32'(low_cnt) < ACK_TO_CLKS))
    else $error("acknowledge wait past deadline");

  // R4: first-data wait never outlives its deadline
  assert_data_deadline_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_DATA) |-> (32'(low_cnt) < DATA_TO_CLKS))
    else $error("first-data wait past deadline");

  // R7: the ready strobe is followed by idle
  assert_ready_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd1_ready_o |=> (state_q == ST_IDLE))
    else $error("ready strobe not followed by idle");

  // R10: a bad block leaves the low states
  assert_crc_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_bad |=> (state_q inside {ST_HOLD, ST_GAP}))
    else $error("bad CRC did not release");

endmodule

// File: tb/flash_boot_reader_tb.sv
module flash_boot_reader_tb;

  localparam int PER  = 2;
  localparam int ACKT = 200;
  localparam int DATT = 400;
  localparam int MINL = 74;
  localparam int GAP  = 56;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       boot_start = 1'b0, abort = 1'b0, abort_now = 1'b0;
  logic       dat0 = 1'b1, blk_done = 1'b0, blk_crc_ok = 1'b1;
  logic       ack_en = 1'b0;
  logic [7:0] mult = 8'd1;
  logic       cmd_oe, cmd_lvl, err_ack, err_data, err_crc, rdy;
  logic [2:0] state;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  flash_boot_reader #(
    .MULT_W(8), .BLOCKS_PER_UNIT(PER), .ACK_TO_CLKS(ACKT),
    .DATA_TO_CLKS(DATT), .MIN_LOW_CLKS(MINL), .GAP_CLKS(GAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_start_i(boot_start), .abort_i(abort),
    .abort_now_i(abort_now), .dat0_i(dat0), .blk_done_i(blk_done),
    .blk_crc_ok_i(blk_crc_ok), .cfg_ack_en_i(ack_en), .cfg_size_mult_i(mult),
    .cmd_oe_o(cmd_oe), .cmd_o(cmd_lvl), .state_o(state), .err_ack_o(err_ack),
    .err_data_o(err_data), .err_crc_o(err_crc), .cmd1_ready_o(rdy)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit low();
    return cmd_oe && !cmd_lvl;
  endfunction

  task automatic kick(input int m, input bit ack);
    mult = 8'(m); ack_en = ack; boot_start = 1'b1;
    tick();
    boot_start = 1'b0;
  endtask

  task automatic pulse_blk(input bit ok);
    blk_done = 1'b1; blk_crc_ok = ok;
    tick();
    blk_done = 1'b0; blk_crc_ok = 1'b1;
  endtask

  task automatic pulse_abort(input bit now);
    abort = 1'b1; abort_now = now;
    tick();
    abort = 1'b0; abort_now = 1'b0;
  endtask

  task automatic send_start_bit();
    dat0 = 1'b0;
    tick();
    dat0 = 1'b1;
  endtask

  task automatic wait_rise(output int c);
    c = -1;
    for (int i = 0; i < 2000; i++) begin
      if (!low()) begin c = cyc; break; end
      tick();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (state == 3'd0) break;
      tick();
    end
  endtask

  task automatic t_reset();
    check("R1", "state", state, 0);
    check("R1", "cmd_oe", cmd_oe, 0);
    check("R1", "cmd level", cmd_lvl, 1);
    check("R1", "errors", {err_ack, err_data, err_crc}, 0);
    check("R1", "ready", rdy, 0);
  endtask

  task automatic t_full_boot();
    int r, got;
    kick(2, 0);
    check("R2", "driven low", low(), 1);
    check("R2", "state wait data", state, 2);
    tick(5);
    send_start_bit();
    check("R4", "state xfer", state, 3);
    tick(100);
    for (int b = 0; b < 3; b++) begin
      pulse_blk(1);
      check("R5", "still low before last block", low(), 1);
      tick(7);
    end
    pulse_blk(1);
    r = cyc;
    check("R5", "state gap after last block", state, 5);
    check("R6", "push-pull high", {cmd_oe, cmd_lvl}, 2'b11);
    got = -1;
    for (int i = 0; i < 200; i++) begin
      if (rdy) begin got = cyc; break; end
      check("R6", "high during gap", {cmd_oe, cmd_lvl}, 2'b11);
      tick();
    end
    check("R7", "ready position", got - r, GAP - 1);
    tick();
    check("R7", "ready one cycle", rdy, 0);
    check("R7", "idle after ready", state, 0);
    check("R7", "released oe", cmd_oe, 0);
  endtask

  task automatic t_ack_ok();
    kick(1, 1);
    check("R3", "state ack", state, 1);
    tick(3);
    dat0 = 1'b0; tick();
    dat0 = 1'b1; tick();
    check("R3", "still ack mid pattern", state, 1);
    dat0 = 1'b0; tick();
    dat0 = 1'b1;
    check("R3", "state wait data after ack", state, 2);
    check("R3", "no ack error", err_ack, 0);
    tick(3);
    send_start_bit();
    check("R4", "xfer after ack", state, 3);
    tick(100);
    pulse_blk(1);
    check("R5", "low after block 1 of 2", low(), 1);
    pulse_blk(1);
    check("R5", "gap after block 2", state, 5);
    wait_idle();
  endtask

  task automatic t_ack_timeout();
    int f, c;
    kick(1, 1);
    f = cyc;
    wait_rise(c);
    check("R3", "low cycles on ack timeout", c - f, ACKT);
    check("R3", "ack error", err_ack, 1);
    wait_idle();
  endtask

  task automatic t_data_timeout();
    int f, c;
    kick(1, 0);
    f = cyc;
    wait_rise(c);
    check("R4", "low cycles on data timeout", c - f, DATT);
    check("R4", "data error", err_data, 1);
    check("R4", "ack error clear", err_ack, 0);
    wait_idle();
  endtask

  task automatic t_abort_min_low();
    int f, c;
    kick(1, 0);
    f = cyc;
    tick(9);
    pulse_abort(1);
    check("R2", "hold state", state, 4);
    check("R2", "still low in hold", low(), 1);
    wait_rise(c);
    check("R2", "min low enforced", c - f, MINL);
    wait_idle();
  endtask

  task automatic t_abort_now_xfer();
    kick(3, 0);
    send_start_bit();
    tick(100);
    pulse_abort(1);
    check("R8", "released next cycle", state, 5);
    pulse_blk(1);
    check("R8", "late block ignored", {cmd_oe, cmd_lvl}, 2'b11);
    wait_idle();
  endtask

  task automatic t_abort_boundary();
    kick(3, 0);
    send_start_bit();
    tick(100);
    pulse_abort(0);
    check("R9", "held low after boundary abort", state, 3);
    tick(20);
    check("R9", "still low mid block", low(), 1);
    pulse_blk(1);
    check("R9", "released at boundary", state, 5);
    wait_idle();
    kick(1, 0);
    tick(100);
    pulse_abort(0);
    check("R9", "released from wait state", state, 5);
    wait_idle();
  endtask

  task automatic t_crc_and_start_rules();
    kick(3, 0);
    send_start_bit();
    tick(100);
    pulse_blk(0);
    check("R10", "released on bad crc", state, 5);
    check("R10", "crc error", err_crc, 1);
    wait_idle();
    check("R11", "crc error sticky in idle", err_crc, 1);
    mult = 8'd0; boot_start = 1'b1;
    tick();
    boot_start = 1'b0;
    check("R11", "zero multiplier ignored", {state, cmd_oe}, 4'b0000);
    kick(1, 0);
    check("R11", "errors cleared by start", err_crc, 0);
    send_start_bit();
    tick(5);
    boot_start = 1'b1; mult = 8'd1;
    tick();
    boot_start = 1'b0;
    check("R11", "busy start ignored", state, 3);
    tick(100);
    pulse_blk(1);
    check("R11", "transfer unaffected", low(), 1);
    pulse_blk(1);
    check("R5", "ends after 2 blocks", state, 5);
    wait_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_full_boot();
    t_ack_ok();
    t_ack_timeout();
    t_data_timeout();
    t_abort_min_low();
    t_abort_now_xfer();
    t_abort_boundary();
    t_crc_and_start_rules();
    summary();
    $finish;
  end

endmodule